// File: doc/BRIEF.md
# Interconnect Test Code Generator and Diagnoser

This block runs a complete board interconnect test over a parameterised set of nets. When a run starts, every net is given its own serial code word. The block then issues the code words bit-column by bit-column, one parallel vector per clock cycle. A board-side path, through boundary-scan cells that lie outside this block, places each vector on the nets. The block collects the bit that comes back on every net in the same cycle.

After the final vector, the block compares each net's received word with the word it sent, and reports the result per net:

- A net whose received word is not its own is marked faulty.
- A faulty net that came back as all zeros is marked open, matching a stuck-at-0 open model.
- Faulty nets that came back with the same non-zero word are marked as members of a short group, matching a wired-AND short model.

Each code word is built in two parts:

- **Base part.** Nets are numbered upward from one. The base part is just wide enough to leave out both the all-zeros value and the all-ones value.
- **Extra top bit.** This bit makes the total number of ones in every word odd. It raises the diagnostic resolution.

The results stay valid until the next run is started.

Top module: `ictest_engine`

## Requirements
- R1: While reset is asserted and after its release, `done` and `drive_valid` are 0, and `drive_vec`, `fault_flag`, `open_flag` and `short_flag` are all zero.
- R2: Let B be ceil(log2(N_NETS+2)). Net i receives a code word of B+1 bits. Bits B-1..0 hold the value i+1, which is never all zeros and never all ones. Bit B is 1 exactly when bits B-1..0 contain an even number of ones. All words are distinct.
- R3: A start accepted at a rising edge is followed by exactly B+1 consecutive cycles with `drive_valid` high. In driving cycle k (k = 0 first), `drive_vec[i]` equals bit k of net i's code word. `drive_vec` is zero whenever `drive_valid` is low.
- R4: At the rising edge that ends driving cycle k, `rx_vec[i]` is taken as bit k of net i's received word.
- R5: `done` rises at the second rising edge after the last driving cycle, and it is never high together with `drive_valid`. It stays high, with all flags unchanged, until the next accepted start.
- R6: `fault_flag[i]` is 1 exactly when net i's received word differs from its sent word.
- R7: `open_flag[i]` is 1 exactly when net i's received word is all zeros. Every open net is also faulty.
- R8: `short_flag[i]` is 1 exactly when all three of these hold: net i is faulty, its received word is non-zero, and at least one other faulty net received the identical word. A short group therefore never has a single member.
- R9: `start` is ignored while driving or analysing. It does not lengthen or restart the run in progress.
- R10: A start accepted while `done` is high begins a new run. `done` and all flags are zero from the accepting edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when sampled high while idle or done |
| drive_valid | output | 1 | High during each of the B+1 driving cycles |
| drive_vec | output | N_NETS | Parallel test vector, one bit per net |
| rx_vec | input | N_NETS | Bits received from the nets during the current driving cycle |
| done | output | 1 | Diagnosis results are valid |
| fault_flag | output | N_NETS | Net received a word other than its own |
| open_flag | output | N_NETS | Net received all zeros |
| short_flag | output | N_NETS | Net belongs to a group of faulty nets with one shared received word |

## Verification
The bench builds the block with six nets. This gives a three-bit base part, four-bit code words and four vectors per run, so every single open, every one of the fifteen two-net shorts, a triple short, two disjoint pairs, a mixed open-plus-short case and a whole-board short all fit within a short run. Its board model applies wired-AND and stuck-at-0 behaviour to whatever the block drives. This reaches the case where the AND of two words equals one of them, which leaves that net clean and the other net faulty alone, and the case where the AND is zero, which makes a short look like two opens. Start pulses made during a run and restarts from the done state are mixed into the sweep.

// File: rtl/ictest_pkg.sv
package ictest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_ANALYZE = 2'd2,
    ST_DONE    = 2'd3
  } run_state_e;

  // Width of the counting part: room for N values with 0 and all-ones left out.
  function automatic int base_w(input int n);
    return $clog2(n + 2);
  endfunction

  // Full word width: counting part plus one odd-weight bit.
  function automatic int code_w(input int n);
    return base_w(n) + 1;
  endfunction

  // Word for net idx out of n nets.
  function automatic logic [31:0] net_code(input int idx, input int n);
    logic [31:0] val;
    int          ones;
    val  = 32'(idx + 1);
    ones = 0;
    for (int j = 0; j < 32; j++) ones += int'(val[j]);
    if ((ones % 2) == 0) val = val | (32'd1 << base_w(n));
    return val;
  endfunction

endpackage

// File: rtl/ictest_codegen.sv
module ictest_codegen #(
  parameter int N_NETS = 8,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0]  col_idx,
  output logic [N_NETS-1:0] column
);
  for (genvar i = 0; i < N_NETS; i++) begin : g_net
    localparam logic [31:0] WORD = ictest_pkg::net_code(i, N_NETS);
    localparam logic [CODE_W-1:0] CODE = WORD[CODE_W-1:0];
    assign column[i] = CODE[col_idx];
  end
endmodule

// File: rtl/ictest_capture.sv
module ictest_capture #(
  parameter int N_NETS = 8,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           capture_en,
  input  logic [IDX_W-1:0]               bit_idx,
  input  logic [N_NETS-1:0]              rx_vec,
  output logic [N_NETS-1:0][CODE_W-1:0]  rx_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_code <= '0;
    end else if (clear) begin
      rx_code <= '0;
    end else if (capture_en) begin
      for (int i = 0; i < N_NETS; i++) rx_code[i][bit_idx] <= rx_vec[i];
    end
  end
endmodule

// File: rtl/ictest_diag.sv
module ictest_diag #(
  parameter int N_NETS = 8,
  parameter int CODE_W = 5
) (
  input  logic [N_NETS-1:0][CODE_W-1:0] rx_code,
  output logic [N_NETS-1:0]             fault,
  output logic [N_NETS-1:0]             open_net,
  output logic [N_NETS-1:0]             short_net
);
  logic [N_NETS-1:0][CODE_W-1:0] sent;

  for (genvar i = 0; i < N_NETS; i++) begin : g_sent
    localparam logic [31:0] WORD = ictest_pkg::net_code(i, N_NETS);
    assign sent[i] = WORD[CODE_W-1:0];
  end

  always_comb begin
    for (int i = 0; i < N_NETS; i++) begin
      fault[i]    = (rx_code[i] != sent[i]);
      open_net[i] = (rx_code[i] == '0);
    end
  end

  always_comb begin
    for (int i = 0; i < N_NETS; i++) begin
      short_net[i] = 1'b0;
      for (int j = 0; j < N_NETS; j++) begin
        if (j != i && fault[j] && rx_code[j] == rx_code[i]) short_net[i] = 1'b1;
      end
      short_net[i] = short_net[i] & fault[i] & ~open_net[i];
    end
  end
endmodule

// File: rtl/ictest_engine.sv
module ictest_engine #(
  parameter int N_NETS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              drive_valid,
  output logic [N_NETS-1:0] drive_vec,
  input  logic [N_NETS-1:0] rx_vec,
  output logic              done,
  output logic [N_NETS-1:0] fault_flag,
  output logic [N_NETS-1:0] open_flag,
  output logic [N_NETS-1:0] short_flag
);
  import ictest_pkg::*;

  localparam int BASE_W = base_w(N_NETS);
  localparam int CODE_W = BASE_W + 1;
  localparam int IDX_W  = $clog2(CODE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

  run_state_e state;
  logic [IDX_W-1:0] vec_idx;

  // Named internal events
  logic start_ok;
  logic capture_en;
  logic last_vec;
  logic analyze_now;

  logic [N_NETS-1:0]             column;
  logic [N_NETS-1:0][CODE_W-1:0] rx_code;
  logic [N_NETS-1:0]             d_fault;
  logic [N_NETS-1:0]             d_open;
  logic [N_NETS-1:0]             d_short;

  assign start_ok    = start && (state == ST_IDLE || state == ST_DONE);
  assign capture_en  = (state == ST_DRIVE);
  assign last_vec    = capture_en && (vec_idx == LAST_IDX);
  assign analyze_now = (state == ST_ANALYZE);

  assign drive_valid = capture_en;
  assign drive_vec   = capture_en ? column : '0;

  ictest_codegen #(.N_NETS(N_NETS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_codegen (
    .col_idx (vec_idx),
    .column  (column)
  );

  ictest_capture #(.N_NETS(N_NETS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .capture_en (capture_en),
    .bit_idx    (vec_idx),
    .rx_vec     (rx_vec),
    .rx_code    (rx_code)
  );

  ictest_diag #(.N_NETS(N_NETS), .CODE_W(CODE_W)) u_diag (
    .rx_code   (rx_code),
    .fault     (d_fault),
    .open_net  (d_open),
    .short_net (d_short)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      vec_idx    <= '0;
      done       <= 1'b0;
      fault_flag <= '0;
      open_flag  <= '0;
      short_flag <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state      <= ST_DRIVE;
            vec_idx    <= '0;
            done       <= 1'b0;
            fault_flag <= '0;
            open_flag  <= '0;
            short_flag <= '0;
          end
        end
        ST_DRIVE: begin
          if (last_vec) state <= ST_ANALYZE;
          else          vec_idx <= vec_idx + 1'b1;
        end
        ST_ANALYZE: begin
          fault_flag <= d_fault;
          open_flag  <= d_open;
          short_flag <= d_short;
          done       <= 1'b1;
          state      <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ictest_checker.sv
module ictest_checker #(
  parameter int N_NETS = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_valid,
  input logic [N_NETS-1:0] drive_vec,
  input logic              done,
  input logic [N_NETS-1:0] fault_flag,
  input logic [N_NETS-1:0] open_flag,
  input logic [N_NETS-1:0] short_flag,
  input logic [IDX_W-1:0]  vec_idx,
  input logic              start_ok
);
  assert_idle_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_valid |-> drive_vec == '0);

  assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_valid && $past(drive_valid) |-> vec_idx == $past(vec_idx) + 1'b1);

  assert_done_excl_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && drive_valid));

  assert_done_after_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(drive_valid, 2) && !$past(drive_valid));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> $stable(fault_flag) && $stable(open_flag) && $stable(short_flag));

  assert_open_is_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (open_flag & ~fault_flag) == '0);

  assert_short_is_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((short_flag & ~fault_flag) == '0) && ((short_flag & open_flag) == '0));

  assert_short_group_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(short_flag) != 1);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_valid |-> !start_ok);

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_ok) |-> !done && fault_flag == '0 && open_flag == '0 && short_flag == '0);
endmodule

bind ictest_engine ictest_checker #(.N_NETS(N_NETS), .IDX_W(IDX_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .drive_valid (drive_valid),
  .drive_vec   (drive_vec),
  .done        (done),
  .fault_flag  (fault_flag),
  .open_flag   (open_flag),
  .short_flag  (short_flag),
  .vec_idx     (vec_idx),
  .start_ok    (start_ok)
);

// File: tb/tb_ictest_engine.sv
`timescale 1ns/1ps
module tb_ictest_engine;
  localparam int N_T  = 6;
  localparam int BW_T = $clog2(N_T + 2);
  localparam int CW_T = BW_T + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic drive_valid;
  logic [N_T-1:0] drive_vec;
  logic [N_T-1:0] rx_vec;
  logic done;
  logic [N_T-1:0] fault_flag, open_flag, short_flag;

  int checks = 0;
  int failures = 0;

  // Board fault configuration
  logic [N_T-1:0] open_m;
  int grp [N_T];
  logic [CW_T-1:0] seen [N_T];

  always #2 clk = ~clk;

  ictest_engine #(.N_NETS(N_T)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .drive_valid(drive_valid), .drive_vec(drive_vec), .rx_vec(rx_vec),
    .done(done), .fault_flag(fault_flag), .open_flag(open_flag), .short_flag(short_flag)
  );

  // Wired-AND shorts, stuck-at-0 opens
  always_comb begin
    for (int i = 0; i < N_T; i++) begin
      logic b;
      b = 1'b1;
      for (int j = 0; j < N_T; j++) if (grp[j] == grp[i]) b = b & drive_vec[j];
      rx_vec[i] = open_m[i] ? 1'b0 : b;
    end
  end

  function automatic logic [CW_T-1:0] tb_code(input int i);
    int v;
    v = i + 1;
    if (($countones(v) % 2) == 0) v = v + (1 << BW_T);
    return CW_T'(v);
  endfunction

  function automatic logic [CW_T-1:0] rx_expect(input int i);
    logic [CW_T-1:0] w;
    if (open_m[i]) return '0;
    w = '1;
    for (int j = 0; j < N_T; j++) if (grp[j] == grp[i]) w = w & tb_code(j);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic identity();
    open_m = '0;
    for (int i = 0; i < N_T; i++) grp[i] = i;
  endtask

  task automatic run_case(input bit poke);
    logic [N_T-1:0] ef, eo, es, col;
    logic [CW_T-1:0] rc [N_T];
    bit was_done;
    was_done = done;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (was_done)
      chk(!done && fault_flag == 0 && open_flag == 0 && short_flag == 0,
          "R10 restart clears", {done, fault_flag, open_flag, short_flag}, 0);
    for (int k = 0; k < CW_T; k++) begin
      for (int i = 0; i < N_T; i++) col[i] = tb_code(i)[k];
      chk(drive_valid == 1'b1, "R3 drive_valid", 32'(drive_valid), 1);
      chk(drive_vec == col, "R2 R3 column", 32'(drive_vec), 32'(col));
      for (int i = 0; i < N_T; i++) seen[i][k] = drive_vec[i];
      start = (poke && k == 1);
      @(negedge clk);
    end
    start = 1'b0;
    chk(!done && !drive_valid, "R5 R9 analyze cycle", {30'd0, done, drive_valid}, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5 done latency", 32'(done), 1);
    for (int i = 0; i < N_T; i++) rc[i] = rx_expect(i);
    for (int i = 0; i < N_T; i++) begin
      ef[i] = (rc[i] != tb_code(i));
      eo[i] = (rc[i] == '0);
    end
    for (int i = 0; i < N_T; i++) begin
      es[i] = 1'b0;
      for (int j = 0; j < N_T; j++) if (j != i && ef[j] && rc[j] == rc[i]) es[i] = 1'b1;
      es[i] = es[i] & ef[i] & ~eo[i];
    end
    chk(fault_flag == ef, "R6 (R4 capture) fault", 32'(fault_flag), 32'(ef));
    chk(open_flag == eo, "R7 open", 32'(open_flag), 32'(eo));
    chk(short_flag == es, "R8 short", 32'(short_flag), 32'(es));
    @(negedge clk);
    chk(done && fault_flag == ef && open_flag == eo && short_flag == es,
        "R5 results hold", {done, fault_flag, open_flag, short_flag}, {1'b1, ef, eo, es});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    identity();
    repeat (3) @(negedge clk);
    chk(!done && !drive_valid && drive_vec == 0, "R1 in reset", {done, drive_valid, drive_vec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !drive_valid && drive_vec == 0 && fault_flag == 0 && open_flag == 0 && short_flag == 0,
        "R1 after reset", {done, drive_valid, drive_vec, fault_flag}, 0);

    // Clean board; also inspect the words the block drove
    identity();
    run_case(1'b0);
    for (int i = 0; i < N_T; i++) begin
      logic [BW_T-1:0] base;
      base = seen[i][BW_T-1:0];
      chk(base != '0 && base != '1 && (seen[i][BW_T] == ~^base),
          "R2 word form", 32'(seen[i]), 32'(tb_code(i)));
      for (int j = i + 1; j < N_T; j++)
        chk(seen[i] != seen[j], "R2 distinct", 32'(seen[i]), 32'(seen[j]));
    end

    // Every single open
    for (int a = 0; a < N_T; a++) begin
      identity(); open_m[a] = 1'b1;
      run_case(a == 2);
    end

    // Every pair short
    for (int a = 0; a < N_T; a++)
      for (int b = a + 1; b < N_T; b++) begin
        identity(); grp[b] = a;
        run_case(((a + b) % 3) == 0);
      end

    // Triple short with an open elsewhere
    identity(); grp[1] = 0; grp[2] = 0; open_m[5] = 1'b1;
    run_case(1'b1);

    // Two disjoint pairs
    identity(); grp[3] = 0; grp[4] = 1;
    run_case(1'b0);

    // Whole board shorted
    identity();
    for (int i = 0; i < N_T; i++) grp[i] = 0;
    run_case(1'b1);

    // Back to clean after faults
    identity();
    run_case(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule